// File: doc/BRIEF.md
# Colour Lookup Table with Deferred Update Queue

This block holds a 256-entry colour lookup table that turns an 8-bit pixel index into a 24-bit RGB value. Host writes do not go straight into the table. They wait in a 64-entry queue. The queue is emptied into the table only while the display timing logic reports that both the horizontal and vertical update windows are open. Because of this, pixels that are being scanned out never see a table that has been changed part way through a line.

The host reads the queue occupancy from a level output, and software must hold off writing while that level is 63 or higher. A write that arrives when all 64 slots are taken is discarded, and an overflow flag is raised. The flag stays set until reset. The lookup port is registered, so a result appears one cycle after its index.

Top module: `clut_stage`

## Requirements
- R1: A host write carries an 8-bit table index and a 32-bit colour word with red in bits 31:24, green in 23:16 and blue in 15:8. Bits 7:0 are ignored. A lookup of a committed entry returns {red, green, blue} as 24 bits, with red in bits 23:16 and blue in bits 7:0.
- R2: `level_o` equals the number of queued writes, from 0 to 64. After a clock edge it counts a write accepted at that edge and subtracts an entry committed at that edge.
- R3: A write presented while the level is 64 is dropped and sets `ovf_o`. `ovf_o` then stays 1 until reset.
- R4: While `upd_h_i` and `upd_v_i` are not both 1, no queued entry reaches the table and the level never decreases.
- R5: While both update inputs are 1 and the queue is not empty, exactly one entry is committed per clock, oldest first. When the same index is written twice, the later write is the value that remains.
- R6: `lut_rgb_o` is registered. The index sampled at one clock edge produces its colour after that edge.
- R7: After reset the level is 0, `ovf_o` is 0, every table entry is 0 and `lut_rgb_o` is 0.
- R8: A lookup sampled at the same edge that commits to that index returns the previous contents. The new contents appear from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host write strobe, one write per cycle |
| wr_index_i | input | 8 | Table entry to update |
| wr_color_i | input | 32 | Colour word: R 31:24, G 23:16, B 15:8 |
| upd_h_i | input | 1 | Horizontal update window from the timing logic |
| upd_v_i | input | 1 | Vertical update window from the timing logic |
| level_o | output | 7 | Number of queued writes |
| ovf_o | output | 1 | Sticky flag for a dropped write |
| lut_index_i | input | 8 | Pixel index for lookup |
| lut_rgb_o | output | 24 | Registered RGB result |

## Verification
The bench fills the queue to 64 and writes once more. A design that counts past the depth, or overwrites the oldest slot, produces a wrong level or a corrupted colour when the queue drains. Each update window is opened on its own, and with only one open a design that drains early changes the lookup result during the visible area. The bench also reads an index on the same edge that commits to it, which exposes a table read taken after the write. It writes one index twice to catch a design that commits out of order. A long stretch of random writes and window patterns then compares level, flag and colour every cycle against a queue-based model.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned CH_W  = 8;
  localparam int unsigned RGB_W = 3 * CH_W;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [RGB_W-1:0] rgb;
  } clut_wr_t;
endpackage

// File: rtl/clut_fifo.sv
module clut_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == LVL_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/clut_table.sv
module clut_table #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned DATA_W = 24,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] ent_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     ent_q[g] <= wr_data_i;
    end
  end

  // read samples pre-commit contents of the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= ent_q[rd_idx_i];
  end
endmodule

// File: rtl/clut_stage.sv
module clut_stage
  import clut_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [IDX_W-1:0]   wr_index_i,
  input  logic [WORD_W-1:0]  wr_color_i,
  input  logic               upd_h_i,
  input  logic               upd_v_i,
  output logic [LVL_W-1:0]   level_o,
  output logic               ovf_o,
  input  logic [IDX_W-1:0]   lut_index_i,
  output logic [RGB_W-1:0]   lut_rgb_o
);
  clut_wr_t in_ent, head_ent;
  logic     full, empty, commit;

  assign in_ent.idx = wr_index_i;
  assign in_ent.rgb = wr_color_i[WORD_W-1 -: RGB_W];
  assign commit     = upd_h_i & upd_v_i & ~empty;

  clut_fifo #(.W($bits(clut_wr_t)), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_valid_i),
    .data_i  (in_ent),
    .pop_i   (commit),
    .head_o  (head_ent),
    .level_o (level_o),
    .full_o  (full),
    .empty_o (empty)
  );

  clut_table #(.IDX_W(IDX_W), .DATA_W(RGB_W)) u_tab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (commit),
    .wr_idx_i  (head_ent.idx),
    .wr_data_i (head_ent.rgb),
    .rd_idx_i  (lut_index_i),
    .rd_data_o (lut_rgb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovf_o <= 1'b0;
    else if (wr_valid_i && full) ovf_o <= 1'b1;
  end
endmodule

// File: rtl/clut_stage_chk.sv
module clut_stage_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             upd_h_i,
  input logic             upd_v_i,
  input logic [LVL_W-1:0] level_o,
  input logic             ovf_o
);
  logic open_w;
  assign open_w = upd_h_i & upd_v_i;

  assert_level_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));

  assert_level_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && level_o < LVL_W'(DEPTH) && !(open_w && level_o != '0))
    |=> level_o == $past(level_o) + 1'b1);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && level_o == LVL_W'(DEPTH)) |=> ovf_o);

  assert_ovf_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  assert_closed_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_w && !wr_valid_i) |=> $stable(level_o));

  assert_one_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_w && !wr_valid_i && level_o != '0) |=> level_o == $past(level_o) - 1'b1);
endmodule

bind clut_stage clut_stage_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .upd_h_i    (upd_h_i),
  .upd_v_i    (upd_v_i),
  .level_o    (level_o),
  .ovf_o      (ovf_o)
);

// File: tb/sim_clut_stage.sv
module sim_clut_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_v = 1'b0;
  logic [7:0]  wr_idx = '0;
  logic [31:0] wr_col = '0;
  logic        uh = 1'b0, uv = 1'b0;
  logic [6:0]  level;
  logic        ovf;
  logic [7:0]  lidx = '0;
  logic [23:0] rgb;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clut_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_v), .wr_index_i(wr_idx),
    .wr_color_i(wr_col), .upd_h_i(uh), .upd_v_i(uv), .level_o(level),
    .ovf_o(ovf), .lut_index_i(lidx), .lut_rgb_o(rgb)
  );

  // behavioural reference
  logic [7:0]  q_idx [$];
  logic [23:0] q_rgb [$];
  logic [23:0] tab [256];
  logic [23:0] m_rgb;
  logic        m_ovf;
  int          sz;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_idx.delete(); q_rgb.delete();
      foreach (tab[i]) tab[i] = '0;
      m_rgb = '0; m_ovf = 0;
    end else begin
      sz = q_idx.size();
      m_rgb = tab[lidx];
      if (uh && uv && sz > 0) begin
        tab[q_idx[0]] = q_rgb[0];
        void'(q_idx.pop_front()); void'(q_rgb.pop_front());
      end
      if (wr_v) begin
        if (sz < 64) begin q_idx.push_back(wr_idx); q_rgb.push_back(wr_col[31:8]); end
        else m_ovf = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(level == 7'(q_idx.size()), "R2 level", 32'(level), 32'(q_idx.size()));
    chk(ovf == m_ovf, "R3 ovf", 32'(ovf), 32'(m_ovf));
    chk(rgb == m_rgb, "R6 lookup", 32'(rgb), 32'(m_rgb));
  end

  task automatic step(); @(negedge clk); endtask

  task automatic put(input logic [7:0] i, input logic [31:0] c);
    wr_v = 1; wr_idx = i; wr_col = c; step(); wr_v = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R7 reset state
    chk(level == 0 && ovf == 0 && rgb == 0, "R7 reset", {level, ovf, rgb}, 0);
    lidx = 8'd3;
    put(8'd3, 32'hA1B2C3FF);
    uh = 1; step(); uh = 0; uv = 1; step(); uv = 0; step();
    // R4 window half-open: nothing committed
    chk(rgb == 0 && level == 1, "R4 gated", {level, rgb}, 32'h01000000);
    uh = 1; uv = 1; step();
    // R8 same-edge lookup sees old contents
    chk(rgb == 24'h0, "R8 old value", rgb, 0);
    step();
    // R1 field mapping, low byte ignored
    chk(rgb == 24'hA1B2C3, "R1 mapping", rgb, 32'hA1B2C3);
    uh = 0; uv = 0;
    // R5 ordering: later write wins
    lidx = 8'd7;
    put(8'd7, 32'h11223300); put(8'd7, 32'h44556600);
    uh = 1; uv = 1; repeat (3) step();
    chk(rgb == 24'h445566, "R5 last wins", rgb, 32'h445566);
    uh = 0; uv = 0;
    // R3 overflow at 64
    for (int i = 0; i < 64; i++) put(8'(i + 16), {8'(i), 8'(~i), 8'(i ^ 5), 8'hEE});
    chk(level == 64 && ovf == 0, "R3 full", {level, ovf}, {7'd64, 1'b0});
    put(8'd200, 32'hDEADBEEF);
    step();
    chk(level == 64 && ovf == 1, "R3 drop", {level, ovf}, {7'd64, 1'b1});
    lidx = 8'd79;
    uh = 1; uv = 1; repeat (66) step();
    chk(level == 0 && ovf == 1, "R3 sticky", {level, ovf}, {7'd0, 1'b1});
    chk(rgb == {8'd63, 8'(~63), 8'(63 ^ 5)}, "R5 drain", rgb, {8'd63, 8'(~63), 8'(63 ^ 5)});
    lidx = 8'd200;
    step();
    chk(rgb == 0, "R3 dropped not stored", rgb, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      wr_v = ($urandom % 3) != 0;
      wr_idx = 8'($urandom % 32);
      wr_col = $urandom;
      uh = ($urandom % 4) == 0;
      uv = ($urandom % 2) == 0;
      lidx = 8'($urandom % 32);
      step();
    end
    wr_v = 0; uh = 0; uv = 0;
    step();
    finish_run();
  end
endmodule